// File: doc/BRIEF.md
# SDRAM Bank State Protocol Checker

This block is a passive, synthesizable observer that sits beside an SDRAM command bus. Each clock it decodes chip select, the three strobes, the bank select, the address bits and the byte-lane masks. From that decode it keeps the open or closed state of every bank, the row last opened in each bank, the mode programmed by the last accepted mode-register load, and the position of the read or write burst in flight. It never drives the bus and stores no data.

Illegal command sequences set bits in a sticky error vector. Those bits stay set until a synchronous clear input is pulsed. In parallel, the block predicts which byte lanes the memory should drive on each cycle of read data. It combines the programmed CAS latency, the burst length and the byte-mask history into that prediction. A system bench or an on-chip debug path can compare the prediction with the real bus.

Top module: `sdram_bank_monitor`

## Requirements
- R1: An activate command (chip select 0, row strobe 0, column strobe 1, write enable 1) marks the selected bank open. It records the address bits as that bank's row, visible on `open_rows[b*12 +: 12]` from the next cycle. The recorded row is kept after the bank closes.
- R2: A read (0,1,0,1) or write (0,1,0,0) addressed to a bank that is closed sets error bit 0.
- R3: A precharge (0,0,1,0) with address bit 10 high closes every bank regardless of the bank select. With bit 10 low, it closes only the selected bank.
- R4: A read or write issued with address bit 10 high closes its bank with no explicit precharge. The bank reads as closed from the cycle that follows the last command-side beat, which is burst-length cycles after the command.
- R5: A mode load (0,0,0,0) with every bank closed takes effect from the next command. Address bits [2:0] select the burst length: codes 0, 1, 2 and 3 give 1, 2, 4 and 8; code 7 gives a full page, which runs until it is cut off; any other code gives 1. Bits [6:4] equal to 2 select CAS latency 2; any other value selects 3. A mode load while any bank is open sets error bit 2 and leaves the mode unchanged. After reset the burst length is 1 and the CAS latency is 2.
- R6: A refresh (0,0,0,1) while any bank is open sets error bit 3. Any command other than no-op or inhibit issued in the TRC_CYC-1 cycles after a refresh sets error bit 4.
- R7: An activate to a bank that is already open sets error bit 1. Every error bit stays set until `err_clr` is high at a clock edge. At that edge the vector becomes all zero, and `err_clr` wins over any error raised in the same cycle.
- R8: For a read in cycle t with CAS latency L and burst length N, `rd_oe_mask` predicts driven lanes in cycles t+L through t+L+N-1. A lane's bit is 0 in any cycle if its `dqm` bit was high two cycles earlier. It is 0 in every cycle outside the read data window.
- R9: A burst stop (0,1,1,0) ends the burst in flight from that cycle on, so no later beats produce read data. If that burst had automatic close pending, its bank closes on the next cycle. A new read or write also cuts off the burst before it in the same way.
- R10: Chip select high (inhibit) and the no-op (0,1,1,1) change no bank state, no row, no mode and no error bit, whatever the other pins carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| err_clr | input | 1 | Synchronous clear of the sticky error vector |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Address bits: row, column, mode and the bit-10 qualifier |
| dqm | input | 4 | Byte-lane masks |
| bank_open | output | 4 | One bit per bank, 1 when the bank is open |
| open_rows | output | 48 | Recorded row per bank, 12 bits each, bank 0 lowest |
| err_flags | output | 5 | Sticky errors: bit 0 access to a closed bank, bit 1 double activate, bit 2 mode load with open bank, bit 3 refresh with open bank, bit 4 command inside the refresh window |
| rd_oe_mask | output | 4 | Predicted driven byte lanes for the current read data cycle |

## Verification
A wrong bank bit shows up on `bank_open` on the cycle after the command that should have changed it. The errors it causes then appear one cycle after the next access to that bank. A miscounted burst or a wrong automatic close moves the close cycle on `bank_open` by one cycle or more. A wrong CAS latency or mask delay shifts `rd_oe_mask` against the bench's queue of scheduled beats on the very first data cycle. For these reasons the bench compares every output on every clock, not only at the end of a sequence.

// File: rtl/sbm_pkg.sv
package sbm_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_LMR,
        CMD_BST
    } cmd_e;

    localparam int NUM_ERR     = 5;
    localparam int ERR_RW_IDLE = 0;
    localparam int ERR_ACT_OPEN = 1;
    localparam int ERR_LMR_OPEN = 2;
    localparam int ERR_REF_OPEN = 3;
    localparam int ERR_REF_WIN  = 4;

    typedef struct packed {
        logic       full_page;
        logic [3:0] burst_len;
        logic       cas3;
    } mode_t;

    localparam mode_t MODE_RESET = '{full_page: 1'b0, burst_len: 4'd1, cas3: 1'b0};

    function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                        input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b010:  c = CMD_PRE;
                3'b001:  c = CMD_REF;
                3'b000:  c = CMD_LMR;
                3'b110:  c = CMD_BST;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

    function automatic mode_t decode_mode(input logic [2:0] len_code, input logic [2:0] lat_code);
        mode_t m;
        m.full_page = 1'b0;
        m.cas3      = (lat_code != 3'd2);
        case (len_code)
            3'd0:    m.burst_len = 4'd1;
            3'd1:    m.burst_len = 4'd2;
            3'd2:    m.burst_len = 4'd4;
            3'd3:    m.burst_len = 4'd8;
            3'd7: begin
                m.burst_len = 4'd1;
                m.full_page = 1'b1;
            end
            default: m.burst_len = 4'd1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sbm_cmd_decode.sv
module sbm_cmd_decode
    import sbm_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    always_comb begin
        cmd = decode_cmd(cs_n, ras_n, cas_n, we_n);
    end
endmodule

// File: rtl/sbm_bank_table.sv
module sbm_bank_table #(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       act_v,
    input  logic                       pre_v,
    input  logic                       pre_all,
    input  logic [BA_W-1:0]            cmd_bank,
    input  logic [ROW_W-1:0]           row_in,
    input  logic                       close_a_v,
    input  logic [BA_W-1:0]            close_a_bank,
    input  logic                       close_b_v,
    input  logic [BA_W-1:0]            close_b_bank,
    output logic [NUM_BANKS-1:0]       bank_open_q,
    output logic [NUM_BANKS*ROW_W-1:0] rows_q
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_cmd;
        logic hit_close;
        always_comb begin
            hit_cmd   = (cmd_bank == BA_W'(b));
            hit_close = (close_a_v && close_a_bank == BA_W'(b)) ||
                        (close_b_v && close_b_bank == BA_W'(b)) ||
                        (pre_v && (pre_all || hit_cmd));
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_open_q[b]              <= 1'b0;
                rows_q[b*ROW_W +: ROW_W]    <= '0;
            end else begin
                if (hit_close) bank_open_q[b] <= 1'b0;
                if (act_v && hit_cmd) begin
                    bank_open_q[b]           <= 1'b1;
                    rows_q[b*ROW_W +: ROW_W] <= row_in;
                end
            end
        end
    end

    // R1: an activate leaves its bank open on the next cycle
    a_r1_act_opens: assert property (@(posedge clk) disable iff (rst)
        act_v |=> bank_open_q[$past(cmd_bank)]);

    // R3: a precharge of all banks leaves none open
    a_r3_pre_all_closes: assert property (@(posedge clk) disable iff (rst)
        (pre_v && pre_all) |=> (bank_open_q == '0));
endmodule

// File: rtl/sbm_burst_track.sv
module sbm_burst_track
    import sbm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int LANES     = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rw_v,
    input  logic             rw_read,
    input  logic             rw_ap,
    input  logic [BA_W-1:0]  rw_bank,
    input  logic             bst_v,
    input  mode_t            mode,
    input  logic [LANES-1:0] dqm,
    output logic             close_old_v,
    output logic [BA_W-1:0]  close_old_bank,
    output logic             close_now_v,
    output logic [BA_W-1:0]  close_now_bank,
    output logic [LANES-1:0] oe_mask
);
    logic            busy, is_rd, fp, ap_pend;
    logic [3:0]      left;
    logic [BA_W-1:0] ap_bank;
    logic            beat_now;
    logic [2:0]      pipe;
    logic [LANES-1:0] dqm_d1, dqm_d2;
    logic            data_phase;

    always_comb begin
        close_old_bank = ap_bank;
        close_old_v    = 1'b0;
        if (rw_v || bst_v) close_old_v = ap_pend;
        else if (busy && !fp && left == 4'd1) close_old_v = ap_pend;
        close_now_bank = rw_bank;
        close_now_v    = rw_v && rw_ap && !mode.full_page && mode.burst_len == 4'd1;
        beat_now       = rw_v ? rw_read : (busy && is_rd && !bst_v);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            is_rd   <= 1'b0;
            fp      <= 1'b0;
            ap_pend <= 1'b0;
            left    <= '0;
            ap_bank <= '0;
        end else if (rw_v) begin
            is_rd   <= rw_read;
            fp      <= mode.full_page;
            busy    <= mode.full_page || mode.burst_len != 4'd1;
            left    <= mode.burst_len - 4'd1;
            ap_pend <= rw_ap && (mode.full_page || mode.burst_len != 4'd1);
            ap_bank <= rw_bank;
        end else if (bst_v) begin
            busy    <= 1'b0;
            ap_pend <= 1'b0;
        end else if (busy && !fp) begin
            if (left == 4'd1) begin
                busy    <= 1'b0;
                ap_pend <= 1'b0;
            end else begin
                left <= left - 4'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe   <= '0;
            dqm_d1 <= '0;
            dqm_d2 <= '0;
        end else begin
            pipe   <= {pipe[1:0], beat_now};
            dqm_d1 <= dqm;
            dqm_d2 <= dqm_d1;
        end
    end

    always_comb begin
        data_phase = mode.cas3 ? pipe[2] : pipe[1];
        oe_mask    = {LANES{data_phase}} & ~dqm_d2;
    end

    // R8: a lane masked two cycles ago is never predicted driven
    a_r8_masked_lane: assert property (@(posedge clk) disable iff (rst)
        ((oe_mask & $past(dqm, 2)) == '0));

    // R9: a burst stop with no new access leaves no burst running
    a_r9_bst_stops: assert property (@(posedge clk) disable iff (rst)
        (bst_v && !rw_v) |=> !busy);
endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
    import sbm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int LANES     = 4,
    parameter int TRC_CYC   = 8,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int TRC_W    = $clog2(TRC_CYC + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       err_clr,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic [ROW_W-1:0]           addr,
    input  logic [LANES-1:0]           dqm,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows,
    output logic [NUM_ERR-1:0]         err_flags,
    output logic [LANES-1:0]           rd_oe_mask
);
    cmd_e             cmd;
    mode_t            mode_q;
    logic [TRC_W-1:0] trc_cnt;
    logic [NUM_ERR-1:0] err_q, err_new;
    logic             any_open, rw_v, bst_v, act_v, pre_v;
    logic             c_old_v, c_now_v;
    logic [BA_W-1:0]  c_old_bank, c_now_bank;

    sbm_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
    );

    always_comb begin
        any_open = |bank_open;
        rw_v     = (cmd == CMD_RD) || (cmd == CMD_WR);
        bst_v    = (cmd == CMD_BST);
        act_v    = (cmd == CMD_ACT);
        pre_v    = (cmd == CMD_PRE);
        err_new                = '0;
        err_new[ERR_RW_IDLE]   = rw_v && !bank_open[ba];
        err_new[ERR_ACT_OPEN]  = act_v && bank_open[ba];
        err_new[ERR_LMR_OPEN]  = (cmd == CMD_LMR) && any_open;
        err_new[ERR_REF_OPEN]  = (cmd == CMD_REF) && any_open;
        err_new[ERR_REF_WIN]   = (trc_cnt != '0) && (cmd != CMD_NOP);
    end

    sbm_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_banks (
        .clk(clk), .rst(rst),
        .act_v(act_v), .pre_v(pre_v), .pre_all(addr[10]),
        .cmd_bank(ba), .row_in(addr),
        .close_a_v(c_old_v), .close_a_bank(c_old_bank),
        .close_b_v(c_now_v), .close_b_bank(c_now_bank),
        .bank_open_q(bank_open), .rows_q(open_rows)
    );

    sbm_burst_track #(.NUM_BANKS(NUM_BANKS), .LANES(LANES)) u_burst (
        .clk(clk), .rst(rst),
        .rw_v(rw_v), .rw_read(cmd == CMD_RD), .rw_ap(addr[10]), .rw_bank(ba),
        .bst_v(bst_v), .mode(mode_q), .dqm(dqm),
        .close_old_v(c_old_v), .close_old_bank(c_old_bank),
        .close_now_v(c_now_v), .close_now_bank(c_now_bank),
        .oe_mask(rd_oe_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_RESET;
            trc_cnt <= '0;
            err_q   <= '0;
        end else begin
            if (cmd == CMD_LMR && !any_open) mode_q <= decode_mode(addr[2:0], addr[6:4]);
            if (cmd == CMD_REF)       trc_cnt <= TRC_W'(TRC_CYC - 1);
            else if (trc_cnt != '0)   trc_cnt <= trc_cnt - 1'b1;
            err_q <= err_clr ? '0 : (err_q | err_new);
        end
    end

    assign err_flags = err_q;

    // R7: without a clear, no error bit ever falls
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        !err_clr |=> ((err_q & $past(err_q)) == $past(err_q)));

    // R6: a refresh always opens the guarded window
    a_r6_trc_window: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REF) |=> (trc_cnt != '0));

    // R5: a rejected mode load leaves the mode unchanged
    a_r5_lmr_rejected: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LMR && any_open) |=> $stable(mode_q));
endmodule

// File: tb/sdram_bank_monitor_tb_top.sv
module sdram_bank_monitor_tb_top;
    localparam int TRC = 8;
    localparam int K_NOP = 0, K_INH = 1, K_ACT = 2, K_RD = 3, K_WR = 4,
                   K_PRE = 5, K_REF = 6, K_LMR = 7, K_BST = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, err_clr, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [3:0]  dqm, bank_open, rd_oe_mask;
    logic [47:0] open_rows;
    logic [4:0]  err_flags;

    sdram_bank_monitor #(.TRC_CYC(TRC)) dut_i (
        .clk(clk), .rst(rst), .err_clr(err_clr), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
        .bank_open(bank_open), .open_rows(open_rows), .err_flags(err_flags),
        .rd_oe_mask(rd_oe_mask)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 0;

    // behavioural reference state
    bit          m_open[4];
    logic [11:0] m_row[4];
    logic [4:0]  m_err;
    int          m_bl, m_cl, ref_until, ap_bank, ap_due;
    bit          ap_pend;
    bit          sched[0:4095];
    logic [3:0]  dqm_hist[0:4095];

    task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s cycle=%0d actual=%0h expected=%0h", tag, cyc, a, e);
        end
    endtask

    function automatic void clear_from(int c);
        for (int i = 0; i < 4096; i++) if (i >= c) sched[i] = 1'b0;
    endfunction

    function automatic void model_step(int t, int kind, int b, logic [11:0] a, logic [3:0] dq, bit clr);
        logic [4:0] ne = '0;
        bit any_o = 1'b0;
        int n;
        for (int i = 0; i < 4; i++) any_o |= m_open[i];
        dqm_hist[t] = dq;
        if (t <= ref_until && kind != K_NOP && kind != K_INH) ne[4] = 1'b1;
        if ((kind == K_RD || kind == K_WR) && !m_open[b]) ne[0] = 1'b1;
        if (kind == K_ACT && m_open[b]) ne[1] = 1'b1;
        if (kind == K_LMR && any_o) ne[2] = 1'b1;
        if (kind == K_REF && any_o) ne[3] = 1'b1;
        if (kind == K_RD || kind == K_WR || kind == K_BST) begin
            clear_from(t + m_cl);
            if (ap_pend) begin m_open[ap_bank] = 1'b0; ap_pend = 1'b0; end
        end else if (ap_pend && ap_due == t + 1) begin
            m_open[ap_bank] = 1'b0;
            ap_pend = 1'b0;
        end
        case (kind)
            K_RD, K_WR: begin
                n = (m_bl == 0) ? 1024 : m_bl;
                if (kind == K_RD)
                    for (int i = 0; i < n; i++) if (t + m_cl + i < 4096) sched[t + m_cl + i] = 1'b1;
                if (a[10]) begin
                    if (n == 1) m_open[b] = 1'b0;
                    else begin ap_pend = 1'b1; ap_bank = b; ap_due = (m_bl == 0) ? 1 << 30 : t + n; end
                end
            end
            K_ACT: begin m_open[b] = 1'b1; m_row[b] = a; end
            K_PRE: begin
                if (a[10]) for (int i = 0; i < 4; i++) m_open[i] = 1'b0;
                else m_open[b] = 1'b0;
            end
            K_REF: ref_until = t + TRC - 1;
            K_LMR: if (!any_o) begin
                case (a[2:0])
                    3'd0: m_bl = 1; 3'd1: m_bl = 2; 3'd2: m_bl = 4; 3'd3: m_bl = 8;
                    3'd7: m_bl = 0; default: m_bl = 1;
                endcase
                m_cl = (a[6:4] == 3'd2) ? 2 : 3;
            end
            default: ;
        endcase
        m_err = clr ? 5'd0 : (m_err | ne);
    endfunction

    task automatic compare(int c);
        logic [3:0]  e_open, e_oe;
        logic [47:0] e_rows;
        for (int i = 0; i < 4; i++) begin
            e_open[i] = m_open[i];
            e_rows[i*12 +: 12] = m_row[i];
        end
        e_oe = (c >= 2 && sched[c]) ? ~dqm_hist[c-2] : 4'h0;
        chk(bank_open == e_open, "R3 bank state", 64'(bank_open), 64'(e_open));
        chk(open_rows == e_rows, "R1 rows", 64'(open_rows), 64'(e_rows));
        chk(err_flags == m_err, "R7 errors", 64'(err_flags), 64'(m_err));
        chk(rd_oe_mask == e_oe, "R8 lane mask", 64'(rd_oe_mask), 64'(e_oe));
    endtask

    task automatic tick(int kind, int b = 0, logic [11:0] a = 12'h0, logic [3:0] dq = 4'h0, bit clr = 1'b0);
        @(negedge clk);
        cs_n = 1'b0; ba = 2'(b); addr = a; dqm = dq; err_clr = clr;
        case (kind)
            K_INH: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000; end
            K_ACT: {ras_n, cas_n, we_n} = 3'b011;
            K_RD:  {ras_n, cas_n, we_n} = 3'b101;
            K_WR:  {ras_n, cas_n, we_n} = 3'b100;
            K_PRE: {ras_n, cas_n, we_n} = 3'b010;
            K_REF: {ras_n, cas_n, we_n} = 3'b001;
            K_LMR: {ras_n, cas_n, we_n} = 3'b000;
            K_BST: {ras_n, cas_n, we_n} = 3'b110;
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        @(posedge clk);
        model_step(cyc, kind, b, a, dq, clr);
        cyc++;
        #1 compare(cyc);
    endtask

    task automatic nops(int n);
        for (int i = 0; i < n; i++) tick(K_NOP);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = '0; end
        m_err = '0; m_bl = 1; m_cl = 2; ref_until = -100; ap_pend = 0; ap_bank = 0; ap_due = 0;
        for (int i = 0; i < 4096; i++) begin sched[i] = 0; dqm_hist[i] = '0; end
        rst = 1'b1; err_clr = 1'b0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        ba = '0; addr = '0; dqm = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        chk(bank_open == 0 && err_flags == 0 && rd_oe_mask == 0, "R1 reset state",
            64'({bank_open, err_flags, rd_oe_mask}), 64'h0);

        tick(K_LMR, 0, 12'h022);                 // burst 4, latency 2
        tick(K_ACT, 0, 12'h123);
        chk(bank_open == 4'b0001 && open_rows[11:0] == 12'h123, "R1 activate",
            64'({bank_open, open_rows[11:0]}), 64'h1123);
        tick(K_ACT, 2, 12'h456);
        // R8: read at t, masks 0011 at t+1
        tick(K_RD, 0, 12'h000);
        tick(K_NOP, 0, 12'h0, 4'b0011);
        chk(rd_oe_mask == 4'hF, "R8 first beat", 64'(rd_oe_mask), 64'hF);
        tick(K_NOP);
        chk(rd_oe_mask == 4'b1100, "R8 masked beat", 64'(rd_oe_mask), 64'hC);
        nops(4);
        chk(rd_oe_mask == 4'h0, "R8 after window", 64'(rd_oe_mask), 64'h0);
        // R4: write with automatic close, burst 4
        tick(K_WR, 2, 12'h400);
        nops(2);
        chk(bank_open[2] == 1'b1, "R4 still open", 64'(bank_open), 64'h5);
        nops(1);
        chk(bank_open[2] == 1'b0, "R4 auto close", 64'(bank_open), 64'h1);
        tick(K_RD, 1);
        chk(err_flags == 5'b00001, "R2 access closed bank", 64'(err_flags), 64'h1);
        tick(K_ACT, 0, 12'h077);
        chk(err_flags == 5'b00011, "R7 double activate", 64'(err_flags), 64'h3);
        nops(1);
        chk(err_flags == 5'b00011, "R7 sticky", 64'(err_flags), 64'h3);
        tick(K_NOP, 0, 12'h0, 4'h0, 1'b1);
        chk(err_flags == 5'b0, "R7 clear", 64'(err_flags), 64'h0);
        nops(4);
        tick(K_INH, 3, 12'h4FF, 4'hF);
        tick(K_NOP, 3, 12'h4FF);
        chk(bank_open == 4'b0001 && err_flags == 0, "R10 no effect",
            64'({bank_open, err_flags}), 64'h20);
        tick(K_LMR, 0, 12'h033);
        chk(err_flags == 5'b00100, "R5 load with open bank", 64'(err_flags), 64'h4);
        tick(K_RD, 0);
        tick(K_NOP);
        chk(rd_oe_mask == 4'hF, "R5 mode kept", 64'(rd_oe_mask), 64'hF);
        nops(5);
        tick(K_PRE, 1, 12'h000);
        chk(bank_open == 4'b0001, "R3 single bank", 64'(bank_open), 64'h1);
        tick(K_PRE, 3, 12'h400);
        chk(bank_open == 4'b0000, "R3 all banks", 64'(bank_open), 64'h0);
        tick(K_NOP, 0, 12'h0, 4'h0, 1'b1);
        // R9: latency 3, burst 8, cut after 3 beats
        tick(K_LMR, 0, 12'h033);
        tick(K_ACT, 3, 12'hABC);
        tick(K_RD, 3, 12'h400);
        nops(2);
        tick(K_BST);
        chk(bank_open[3] == 1'b0, "R9 close on stop", 64'(bank_open), 64'h0);
        tick(K_NOP);
        chk(rd_oe_mask == 4'hF, "R8 last beat", 64'(rd_oe_mask), 64'hF);
        tick(K_NOP);
        chk(rd_oe_mask == 4'h0, "R9 no beat after stop", 64'(rd_oe_mask), 64'h0);
        nops(3);
        // R6 refresh window
        tick(K_REF);
        tick(K_ACT, 0, 12'h010);
        chk(err_flags == 5'b10000, "R6 command in window", 64'(err_flags), 64'h10);
        tick(K_NOP, 0, 12'h0, 4'h0, 1'b1);
        nops(8);
        tick(K_REF);
        chk(err_flags == 5'b01000, "R6 refresh open bank", 64'(err_flags), 64'h8);
        tick(K_NOP, 0, 12'h0, 4'h0, 1'b1);
        nops(6);
        tick(K_PRE, 0, 12'h400);
        chk(err_flags == 5'b0, "R6 window over", 64'(err_flags), 64'h0);
        // full page
        tick(K_LMR, 0, 12'h027);
        tick(K_ACT, 1, 12'h200);
        tick(K_RD, 1);
        nops(20);
        chk(rd_oe_mask == 4'hF, "R5 full page runs", 64'(rd_oe_mask), 64'hF);
        tick(K_BST);
        nops(3);
        chk(rd_oe_mask == 4'h0, "R9 full page stopped", 64'(rd_oe_mask), 64'h0);
        tick(K_RD, 1);
        tick(K_NOP, 0, 12'h0, 4'b1010);
        tick(K_WR, 1);
        tick(K_BST);
        nops(6);

        done = 1;
        summary();
        $finish;
    end
endmodule